// File: doc/BRIEF.md
# Decimal Carry-Skip Subtractor

This block adds or subtracts two unsigned packed decimal operands of `DIGITS` digits each. Each digit is four bits wide and holds a value from 0 to 9. In subtract mode every subtrahend digit passes through a selectable nine's complementer. The complementer inverts the digit and then adds ten, modulo 16. Bit 0 of the complemented digit is not fed into the operand. It drives the carry input of the first-level 4-bit adder, and a zero takes its place in the operand. A first level that is carry-skip can then forward that carry through its block-propagate path.

The carry from the next lower digit enters in the second, correction level. The correction level is also a 4-bit carry-skip adder, which adds the decimal correction of six. In subtract mode, a final decimal carry of one means the difference is positive, and the sum is incremented as an end-around carry. A final carry of zero means the difference is negative: the sum is recomplemented and the negative flag is set. When the operands are equal, the result is zero and it is treated as positive.

All three results are registered once at the block's output.

Top module: `bcd_skip_sub`

## Requirements
- R1: With `sub_i`=0, `{carry_o, diff_o}` equals the decimal sum X+Y, and `neg_o` is 0.
- R2: With `sub_i`=1 and X>Y, `diff_o` equals X−Y, `carry_o` is 1 and `neg_o` is 0.
- R3: With `sub_i`=1 and X<Y, `diff_o` equals the magnitude Y−X, `neg_o` is 1 and `carry_o` is 0.
- R4: With `sub_i`=1 and X=Y, `diff_o` is zero and both `neg_o` and `carry_o` are 0.
- R5: For decimal inputs, every 4-bit digit of `diff_o` lies in 0..9, and `neg_o` and `carry_o` are never both 1.
- R6: While `rst_ni` is low, all outputs are zero. After reset, the outputs reflect the inputs present at the preceding rising edge of `clk_i`, so results arrive one cycle after their inputs.
- R7: Digit k occupies bits [4k+3:4k] of `x_i`, `y_i` and `diff_o`, and digit 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| x_i | input | 4*DIGITS | Minuend or first addend, packed decimal |
| y_i | input | 4*DIGITS | Subtrahend or second addend, packed decimal |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| diff_o | output | 4*DIGITS | Decimal sum, or the magnitude of the difference |
| carry_o | output | 1 | Final decimal carry of the digit chain |
| neg_o | output | 1 | Difference is negative (subtract mode only) |

## Verification
All results are due exactly one rising edge after their inputs are applied, because the arithmetic itself has no state. The bench changes inputs on a falling edge and compares all three outputs on the next falling edge, so the single capturing edge lies between the two. The checker waits one full cycle after reset before it uses `$past`, so its first comparison is against a registered value that came from real inputs.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] NINE = 4'd9;
  localparam logic [DIGIT_W-1:0] TEN  = 4'b1010;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_nines_cmp.sv
module bcd_nines_cmp
  import bcd_sub_pkg::*;
(
  input  logic   sel_i,
  input  digit_t d_i,
  output digit_t q_o
);
  digit_t inv_d;
  digit_t cmp_d;

  // ones' complement by inversion, then +10 mod 16 gives 9-d
  assign inv_d = ~d_i;
  assign cmp_d = inv_d + TEN;
  assign q_o   = sel_i ? cmp_d : d_i;
endmodule

// File: rtl/bcd_skip_add4.sv
module bcd_skip_add4
  import bcd_sub_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  input  logic   c_i,
  output digit_t s_o,
  output logic   c_o
);
  logic [DIGIT_W:0]   c;
  logic [DIGIT_W-1:0] p;
  logic [DIGIT_W-1:0] g;

  assign c[0] = c_i;
  for (genvar i = 0; i < DIGIT_W; i++) begin : g_bit
    assign p[i]   = a_i[i] ^ b_i[i];
    assign g[i]   = a_i[i] & b_i[i];
    assign s_o[i] = p[i] ^ c[i];
    assign c[i+1] = g[i] | (p[i] & c[i]);
  end

  // block propagate forwards the carry-in past the ripple chain
  assign c_o = (&p) ? c_i : c[DIGIT_W];
endmodule

// File: rtl/bcd_skip_digit.sv
module bcd_skip_digit
  import bcd_sub_pkg::*;
(
  input  digit_t x_i,
  input  digit_t n_i,
  input  logic   c_i,
  output digit_t s_o,
  output logic   c_o
);
  digit_t t;
  logic   t_c;
  logic   dc;
  logic   lvl2_c_unused;

  // n[0] rides in as carry-in, operand carries a zero in its place
  bcd_skip_add4 u_lvl1 (
    .a_i(x_i),
    .b_i({n_i[3:1], 1'b0}),
    .c_i(n_i[0]),
    .s_o(t),
    .c_o(t_c)
  );

  // decimal carry of t + c_i, t in 0..18
  assign dc = t_c | (t[3] & (t[2] | t[1])) | (c_i & t[3] & t[0]);

  // lower-digit carry applied in the correction level
  bcd_skip_add4 u_lvl2 (
    .a_i(t),
    .b_i({1'b0, dc, dc, 1'b0}),
    .c_i(c_i),
    .s_o(s_o),
    .c_o(lvl2_c_unused)
  );

  assign c_o = dc;
endmodule

// File: rtl/bcd_inc.sv
module bcd_inc
  import bcd_sub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] v_i,
  input  logic         c_i,
  output logic [W-1:0] s_o
);
  logic [DIGITS:0] c;

  assign c[0] = c_i;
  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    digit_t d;
    logic   top;
    assign d   = v_i[k*DIGIT_W +: DIGIT_W];
    assign top = (d == NINE);
    assign s_o[k*DIGIT_W +: DIGIT_W] = !c[k] ? d : (top ? '0 : d + 4'd1);
    assign c[k+1] = c[k] & top;
  end
endmodule

// File: rtl/bcd_skip_sub.sv
module bcd_skip_sub
  import bcd_sub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] diff_o,
  output logic         carry_o,
  output logic         neg_o
);
  logic [W-1:0]    n_vec;
  logic [W-1:0]    sum;
  logic [W-1:0]    sum_inc;
  logic [W-1:0]    sum_rec;
  logic [DIGITS:0] c;
  logic            all_nine;
  logic            pos;
  logic [W-1:0]    res_d;
  logic            neg_d;

  assign c[0] = 1'b0;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    bcd_nines_cmp u_cmp (
      .sel_i(sub_i),
      .d_i  (y_i[k*DIGIT_W +: DIGIT_W]),
      .q_o  (n_vec[k*DIGIT_W +: DIGIT_W])
    );

    bcd_skip_digit u_add (
      .x_i(x_i[k*DIGIT_W +: DIGIT_W]),
      .n_i(n_vec[k*DIGIT_W +: DIGIT_W]),
      .c_i(c[k]),
      .s_o(sum[k*DIGIT_W +: DIGIT_W]),
      .c_o(c[k+1])
    );

    bcd_nines_cmp u_rec (
      .sel_i(1'b1),
      .d_i  (sum[k*DIGIT_W +: DIGIT_W]),
      .q_o  (sum_rec[k*DIGIT_W +: DIGIT_W])
    );
  end

  // end-around carry
  bcd_inc #(.DIGITS(DIGITS)) u_inc (
    .v_i(sum),
    .c_i(1'b1),
    .s_o(sum_inc)
  );

  // all-nines sum means equal operands: fold to positive zero
  assign all_nine = (sum == {DIGITS{NINE}});
  assign pos      = c[DIGITS] | all_nine;

  always_comb begin
    if (!sub_i) begin
      res_d = sum;
      neg_d = 1'b0;
    end else begin
      res_d = pos ? sum_inc : sum_rec;
      neg_d = !pos;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diff_o  <= '0;
      carry_o <= 1'b0;
      neg_o   <= 1'b0;
    end else begin
      diff_o  <= res_d;
      carry_o <= c[DIGITS];
      neg_o   <= neg_d;
    end
  end
endmodule

// File: rtl/bcd_skip_sub_chk.sv
module bcd_skip_sub_chk
  import bcd_sub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * DIGIT_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic         sub_i,
  input logic [W-1:0] diff_o,
  input logic         carry_o,
  input logic         neg_o
);
  logic primed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  function automatic logic digits_ok(logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (v[k*DIGIT_W +: DIGIT_W] > NINE) ok = 1'b0;
    return ok;
  endfunction

  p_reset_clear_r6: assert property (@(posedge clk_i)
    !rst_ni |-> (diff_o == '0 && !carry_o && !neg_o));

  p_add_not_neg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    !$past(sub_i) |-> !neg_o);

  p_add_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    (!$past(sub_i) && $past(y_i) == '0) |-> (diff_o == $past(x_i) && !carry_o));

  p_sub_equal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    ($past(sub_i) && $past(x_i) == $past(y_i)) |-> (diff_o == '0 && !neg_o && !carry_o));

  p_sub_self_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    ($past(sub_i) && $past(y_i) == '0 && $past(x_i) != '0) |-> (diff_o == $past(x_i) && carry_o && !neg_o));

  p_flags_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    !(neg_o && carry_o));

  p_digit_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    (digits_ok($past(x_i)) && digits_ok($past(y_i))) |-> digits_ok(diff_o));

  p_neg_borrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    neg_o |-> $past(sub_i));
endmodule

bind bcd_skip_sub bcd_skip_sub_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/bcd_skip_sub_bench.sv
module bcd_skip_sub_bench;
  localparam int ND = 4;
  localparam int W  = ND * 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] x4 = '0, y4 = '0, d4;
  logic         s4 = 1'b0, c4, n4;
  logic [3:0]   x1 = '0, y1 = '0, d1;
  logic         s1 = 1'b0, c1, n1;

  int nvec = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  bcd_skip_sub #(.DIGITS(ND)) u_bcd_skip_sub (
    .clk_i(clk), .rst_ni(rst_ni), .x_i(x4), .y_i(y4), .sub_i(s4),
    .diff_o(d4), .carry_o(c4), .neg_o(n4)
  );

  bcd_skip_sub #(.DIGITS(1)) u_bcd_skip_sub_1d (
    .clk_i(clk), .rst_ni(rst_ni), .x_i(x1), .y_i(y1), .sub_i(s1),
    .diff_o(d1), .carry_o(c1), .neg_o(n1)
  );

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r;
    int t;
    t = v;
    r = '0;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic digits_ok(logic [W-1:0] v);
    for (int i = 0; i < ND; i++)
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  // expected {carry, neg, diff} and the requirement it exercises
  task automatic model(input int xv, input int yv, input bit sub, input int nd,
                       output logic [W+1:0] e, output string tag);
    int m;
    m = 1;
    for (int i = 0; i < nd; i++) m = m * 10;
    if (!sub) begin
      e = {((xv + yv) >= m), 1'b0, to_bcd((xv + yv) % m)};
      tag = "R1";
    end else if (xv > yv) begin
      e = {1'b1, 1'b0, to_bcd(xv - yv)};
      tag = "R2";
    end else if (xv < yv) begin
      e = {1'b0, 1'b1, to_bcd(yv - xv)};
      tag = "R3";
    end else begin
      e = {1'b0, 1'b0, to_bcd(0)};
      tag = "R4";
    end
  endtask

  task automatic compare(string tag, logic [W+1:0] act, logic [W+1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got carry/neg/diff %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run4(int xv, int yv, bit sub);
    logic [W+1:0] e;
    string tag;
    @(negedge clk);
    x4 = to_bcd(xv); y4 = to_bcd(yv); s4 = sub;
    @(negedge clk);
    model(xv, yv, sub, ND, e, tag);
    compare(tag, {c4, n4, d4}, e);
    nvec++;
    if (!digits_ok(d4) || (c4 && n4)) begin
      nbad++;
      $display("FAIL R5: diff %h carry %b neg %b expected decimal digits, flags exclusive",
               d4, c4, n4);
    end
  endtask

  task automatic run1(int xv, int yv, bit sub);
    logic [W+1:0] e;
    string tag;
    @(negedge clk);
    x1 = 4'(xv); y1 = 4'(yv); s1 = sub;
    @(negedge clk);
    model(xv, yv, sub, 1, e, tag);
    compare(tag, {c1, n1, 12'h000, d1}, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    // R6: outputs held at zero during reset with live inputs
    x4 = to_bcd(1234); y4 = to_bcd(777); s4 = 1'b0;
    x1 = 4'd7; y1 = 4'd8;
    repeat (3) @(negedge clk);
    compare("R6", {c4, n4, d4}, '0);
    compare("R6", {c1, n1, 12'h000, d1}, '0);
    rst_ni = 1'b1;

    // R6: one-cycle latency, result after a single capturing edge
    @(negedge clk);
    x4 = to_bcd(25); y4 = to_bcd(17); s4 = 1'b0;
    @(negedge clk);
    compare("R6", {c4, n4, d4}, {2'b00, to_bcd(42)});

    // R7: digit 0 is the low nibble
    @(negedge clk);
    x4 = 16'h0001; y4 = 16'h0000; s4 = 1'b0;
    @(negedge clk);
    compare("R7", {c4, n4, d4}, {2'b00, 16'h0001});
    @(negedge clk);
    x4 = 16'h0000; y4 = 16'h1000; s4 = 1'b1;
    @(negedge clk);
    compare("R7", {c4, n4, d4}, {2'b01, 16'h1000});

    // exhaustive single digit, both modes
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 10; a++)
        for (int b = 0; b < 10; b++)
          run1(a, b, m[0]);

    // four-digit corners
    run4(9999, 9999, 1'b0);
    run4(9999, 1, 1'b0);
    run4(0, 0, 1'b0);
    run4(0, 9999, 1'b1);
    run4(9999, 0, 1'b1);
    run4(5000, 5000, 1'b1);
    run4(1, 0, 1'b1);
    run4(0, 1, 1'b1);
    run4(1000, 999, 1'b1);
    run4(999, 1000, 1'b1);
    run4(9999, 9999, 1'b1);

    // random four-digit operands
    for (int i = 0; i < 3000; i++) begin
      int a, b;
      a = int'($urandom_range(0, 9999));
      b = (i % 10 == 0) ? a : int'($urandom_range(0, 9999));
      run4(a, b, i[0]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule